// File: doc/BRIEF.md
# Fine-Grained Multithread Issue Scheduler

This block decides, in every cycle, which hardware thread context may issue into a single-issue pipeline that several threads share. It keeps one availability flag per thread. Among the threads that are both available and presenting an instruction, it rotates in round-robin order, starting from the thread after the one that issued last. When no thread qualifies, it reports an idle cycle, so the pipeline inserts a bubble.

Loads are scheduled as if they always hit. A thread that has just issued a load may issue again in the following cycles, and those instructions are speculative. The miss indication for a load arrives a fixed number of cycles (`MISS_LAT`, default 2) after the load issues. When it arrives, the scheduler asks the pipeline to squash whatever that thread issued after the load. It also withdraws the thread from selection, and returns it to selection only when its fill-return pulse arrives. The grant is taken unconditionally in every cycle: the pipeline applies no back-pressure, so the issue output is a plain valid/ID pair and not a handshake. The miss, fill and flush signals are plain per-thread pulses.

Top module: `mts_issue_sched`

## Requirements
- R1: When all four threads present an instruction and none has an outstanding miss, the issued thread IDs run 0,1,2,3,0,... with no repeats or skips.
- R2: The issued thread is the first one that is ready and available, counting upward (modulo the thread count) from the thread after the last one that issued. Threads that are not ready or not available are skipped.
- R3: If exactly one thread is eligible, it issues in every consecutive cycle.
- R4: When no thread is eligible, `idle` is 1 and `issue_valid` is 0 in that same cycle.
- R5: A miss for thread t that arrives exactly `MISS_LAT` cycles after a load issued from t removes t from selection in the miss cycle itself and in every later cycle, until a fill returns.
- R6: In the cycle of such an accepted miss, `flush_req[t]` is 1 exactly when thread t issued at least one instruction in the cycles strictly between the load and the miss. Otherwise it stays 0.
- R7: A fill-return pulse for an unavailable thread makes it eligible again from the next cycle. In the pulse cycle itself it is still skipped.
- R8: A miss pulse for a thread that did not issue a load exactly `MISS_LAT` cycles earlier is ignored. It causes no flush, and the thread stays selectable.
- R9: After reset every thread is available, no flush is requested, and the first grant with all threads ready goes to thread 0.
- R10: A load that receives no miss leaves its thread available. The thread keeps issuing without a flush.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| thr_ready | input | N_THREADS | Thread t has an instruction to issue this cycle |
| issue_load | input | 1 | The instruction granted this cycle is a load |
| ld_miss | input | N_THREADS | Miss report for thread t's load issued MISS_LAT cycles ago |
| fill_ret | input | N_THREADS | Fill for thread t's missing load has returned |
| issue_valid | output | 1 | A thread is granted this cycle |
| issue_tid | output | $clog2(N_THREADS) | ID of the granted thread |
| idle | output | 1 | No thread eligible; pipeline inserts a bubble |
| flush_req | output | N_THREADS | Squash thread t's instructions issued after its missed load |

## Verification
A rotation pointer that is out of step shows up as a wrong `issue_tid` in the first cycle where two or more threads compete. The sweep therefore places the pointer on every thread, and under each position presents every ready mask. An availability flag that is stuck or cleared at the wrong time appears within one cycle as a grant to a thread that should be parked, or as an idle cycle where a grant was due. This is checked around accepted misses, early or unmatched miss pulses, and fills. A load history that is shifted wrongly shows up in the miss cycle, as a missing or spurious `flush_req` or as a miss that is accepted in the wrong cycle.

// File: rtl/mts_pkg.sv
package mts_pkg;
  localparam int unsigned MTS_THREADS_DEF  = 4;
  localparam int unsigned MTS_MISS_LAT_DEF = 2;
endpackage

// File: rtl/mts_rr_pick.sv
module mts_rr_pick #(
  parameter int unsigned N  = 4,
  parameter int unsigned TW = $clog2(N)
) (
  input  logic [N-1:0]  elig,
  input  logic [TW-1:0] start,
  output logic          gnt_valid,
  output logic [TW-1:0] gnt_tid,
  output logic [N-1:0]  gnt_onehot
);
  int unsigned idx;

  always_comb begin
    gnt_valid = 1'b0;
    gnt_tid   = '0;
    idx       = 0;
    for (int unsigned i = 0; i < N; i++) begin
      idx = (int'(start) + i) % N;
      if (!gnt_valid && elig[idx]) begin
        gnt_valid = 1'b1;
        gnt_tid   = TW'(idx);
      end
    end
    gnt_onehot = gnt_valid ? (N'(1) << gnt_tid) : '0;
  end
endmodule

// File: rtl/mts_thread_ctx.sv
module mts_thread_ctx #(
  parameter int unsigned LAT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ready,
  input  logic granted,
  input  logic granted_load,
  input  logic miss,
  input  logic fill,
  output logic eligible,
  output logic flush
);
  logic           avail;
  logic [LAT-1:0] ld_hist;
  logic [LAT-1:0] is_hist;
  logic           miss_ok;

  assign miss_ok  = miss & ld_hist[LAT-1];
  assign eligible = avail & ready & ~miss_ok;
  assign flush    = miss_ok & (|is_hist[LAT-2:0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      avail   <= 1'b1;
      ld_hist <= '0;
      is_hist <= '0;
    end else if (miss_ok) begin
      avail   <= 1'b0;
      ld_hist <= '0;
      is_hist <= '0;
    end else begin
      if (fill) avail <= 1'b1;
      ld_hist <= {ld_hist[LAT-2:0], granted_load};
      is_hist <= {is_hist[LAT-2:0], granted};
    end
  end
endmodule

// File: rtl/mts_issue_sched.sv
module mts_issue_sched #(
  parameter int unsigned N_THREADS = mts_pkg::MTS_THREADS_DEF,
  parameter int unsigned MISS_LAT  = mts_pkg::MTS_MISS_LAT_DEF,
  localparam int unsigned TW       = $clog2(N_THREADS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_THREADS-1:0] thr_ready,
  input  logic                 issue_load,
  input  logic [N_THREADS-1:0] ld_miss,
  input  logic [N_THREADS-1:0] fill_ret,
  output logic                 issue_valid,
  output logic [TW-1:0]        issue_tid,
  output logic                 idle,
  output logic [N_THREADS-1:0] flush_req
);
  logic [N_THREADS-1:0] elig;
  logic [N_THREADS-1:0] gnt_oh;
  logic [TW-1:0]        rr_ptr;

  for (genvar t = 0; t < N_THREADS; t++) begin : g_ctx
    mts_thread_ctx #(.LAT(MISS_LAT)) u_ctx (
      .clk          (clk),
      .rst_n        (rst_n),
      .ready        (thr_ready[t]),
      .granted      (gnt_oh[t]),
      .granted_load (gnt_oh[t] & issue_load),
      .miss         (ld_miss[t]),
      .fill         (fill_ret[t]),
      .eligible     (elig[t]),
      .flush        (flush_req[t])
    );
  end

  mts_rr_pick #(.N(N_THREADS), .TW(TW)) u_pick (
    .elig       (elig),
    .start      (rr_ptr),
    .gnt_valid  (issue_valid),
    .gnt_tid    (issue_tid),
    .gnt_onehot (gnt_oh)
  );

  assign idle = ~issue_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rr_ptr <= '0;
    end else if (issue_valid) begin
      rr_ptr <= (int'(issue_tid) == N_THREADS - 1) ? '0 : issue_tid + TW'(1);
    end
  end
endmodule

// File: rtl/mts_sched_chk.sv
module mts_sched_chk #(
  parameter int unsigned N_THREADS = mts_pkg::MTS_THREADS_DEF,
  parameter int unsigned MISS_LAT  = mts_pkg::MTS_MISS_LAT_DEF,
  localparam int unsigned TW       = $clog2(N_THREADS)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [N_THREADS-1:0] thr_ready,
  input logic                 issue_load,
  input logic [N_THREADS-1:0] ld_miss,
  input logic [N_THREADS-1:0] fill_ret,
  input logic                 issue_valid,
  input logic [TW-1:0]        issue_tid,
  input logic                 idle,
  input logic [N_THREADS-1:0] flush_req
);
  AST_GRANT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> thr_ready[issue_tid]); // R2

  AST_IDLE_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_ready == '0) |-> (idle && !issue_valid)); // R4

  for (genvar t = 0; t < N_THREADS; t++) begin : g_chk
    AST_FLUSH_WITH_MISS: assert property (@(posedge clk) disable iff (!rst_n)
      flush_req[t] |-> ld_miss[t]); // R6

    AST_FLUSH_NOT_GRANTED: assert property (@(posedge clk) disable iff (!rst_n)
      flush_req[t] |-> !(issue_valid && (int'(issue_tid) == t))); // R5
  end
endmodule

bind mts_issue_sched mts_sched_chk #(
  .N_THREADS (N_THREADS),
  .MISS_LAT  (MISS_LAT)
) u_chk (.*);

// File: tb/mts_issue_sched_tb.sv
`timescale 1ns/1ps
module mts_issue_sched_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] thr_ready;
  logic       issue_load;
  logic [3:0] ld_miss;
  logic [3:0] fill_ret;
  logic       issue_valid;
  logic [1:0] issue_tid;
  logic       idle;
  logic [3:0] flush_req;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  mts_issue_sched u_dut (
    .clk(clk), .rst_n(rst_n), .thr_ready(thr_ready), .issue_load(issue_load),
    .ld_miss(ld_miss), .fill_ret(fill_ret), .issue_valid(issue_valid),
    .issue_tid(issue_tid), .idle(idle), .flush_req(flush_req)
  );

  function automatic int pick(input logic [3:0] mask, input int p);
    for (int i = 0; i < 4; i++) begin
      if (mask[(p + i) % 4]) return (p + i) % 4;
    end
    return -1;
  endfunction

  task automatic step(input logic [3:0] rdy, input logic ld, input logic [3:0] ms,
                      input logic [3:0] fl, input int exp_tid, input logic [3:0] exp_fl,
                      input string req);
    int got;
    @(negedge clk);
    thr_ready = rdy; issue_load = ld; ld_miss = ms; fill_ret = fl;
    #1;
    got = issue_valid ? int'(issue_tid) : -1;
    total++;
    if (got != exp_tid || idle != (exp_tid < 0) || flush_req != exp_fl) begin
      bad++;
      $display("FAIL %s: tid=%0d idle=%0b flush=%b expected tid=%0d idle=%0b flush=%b",
               req, got, idle, flush_req, exp_tid, (exp_tid < 0), exp_fl);
    end
  endtask

  initial begin
    #2000000;
    bad++;
    total++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; thr_ready = '0; issue_load = 1'b0; ld_miss = '0; fill_ret = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R9 / R4: reset state, nothing ready
    step(4'h0, 0, 4'h0, 4'h0, -1, 4'h0, "R9");
    // R1 / R9: full rotation from thread 0
    for (int i = 0; i < 8; i++) step(4'hF, 0, 4'h0, 4'h0, i % 4, 4'h0, "R1");

    // R2 / R4: every pointer position against every ready mask
    for (int p = 0; p < 4; p++) begin
      for (int m = 0; m < 16; m++) begin
        step(4'(1 << ((p + 3) % 4)), 0, 4'h0, 4'h0, (p + 3) % 4, 4'h0, "R2");
        step(4'(m), 0, 4'h0, 4'h0, pick(4'(m), p), 4'h0, (m == 0) ? "R4" : "R2");
      end
    end

    // R3: single eligible thread issues back to back
    for (int i = 0; i < 3; i++) step(4'h4, 0, 4'h0, 4'h0, 2, 4'h0, "R3");

    // R5 / R6: load on t0, speculative issue, miss two cycles later
    step(4'h1, 1, 4'h0, 4'h0, 0, 4'h0, "R5");
    step(4'h1, 0, 4'h0, 4'h0, 0, 4'h0, "R6");
    step(4'h1, 0, 4'h1, 4'h0, -1, 4'h1, "R6");
    step(4'h1, 0, 4'h0, 4'h0, -1, 4'h0, "R5");
    step(4'hF, 0, 4'h0, 4'h0, 1, 4'h0, "R5");
    // R7: fill returns, eligible one cycle later
    step(4'h1, 0, 4'h0, 4'h1, -1, 4'h0, "R7");
    step(4'h1, 0, 4'h0, 4'h0, 0, 4'h0, "R7");

    // R6: miss with no speculative issue from that thread -> no flush
    step(4'h2, 1, 4'h0, 4'h0, 1, 4'h0, "R6");
    step(4'h4, 0, 4'h0, 4'h0, 2, 4'h0, "R6");
    step(4'h6, 0, 4'h2, 4'h0, 2, 4'h0, "R6");
    step(4'h2, 0, 4'h0, 4'h0, -1, 4'h0, "R5");
    step(4'h2, 0, 4'h0, 4'h2, -1, 4'h0, "R7");
    step(4'h2, 0, 4'h0, 4'h0, 1, 4'h0, "R7");

    // R8: miss on a thread with no load two cycles earlier
    step(4'h8, 0, 4'h8, 4'h0, 3, 4'h0, "R8");
    step(4'h8, 0, 4'h0, 4'h0, 3, 4'h0, "R8");
    // R8: load on t0, miss reported for t1 instead
    step(4'h1, 1, 4'h0, 4'h0, 0, 4'h0, "R8");
    step(4'h1, 0, 4'h0, 4'h0, 0, 4'h0, "R8");
    step(4'h3, 0, 4'h2, 4'h0, 1, 4'h0, "R8");
    step(4'h1, 0, 4'h0, 4'h0, 0, 4'h0, "R8");
    // R8: miss one cycle too early is ignored
    step(4'h1, 1, 4'h0, 4'h0, 0, 4'h0, "R8");
    step(4'h1, 0, 4'h1, 4'h0, 0, 4'h0, "R8");
    step(4'h1, 0, 4'h0, 4'h0, 0, 4'h0, "R8");

    // R10: load that hits keeps the thread running
    step(4'h4, 1, 4'h0, 4'h0, 2, 4'h0, "R10");
    step(4'h4, 0, 4'h0, 4'h0, 2, 4'h0, "R10");
    step(4'h4, 0, 4'h0, 4'h0, 2, 4'h0, "R10");
    step(4'h4, 0, 4'h0, 4'h0, 2, 4'h0, "R10");

    @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule